// File: doc/BRIEF.md
# Seeded CRC16 Generator and Checker

This block computes a 16-bit checksum over a packet payload that arrives one byte per accepted beat. In transmit mode it shows the checksum to be appended after the payload. In receive mode it takes the two checksum bytes that follow the payload and reports whether they are correct. The polynomial is x^16 + x^15 + x^2 + 1. The starting value of the checksum register is programmable.

Two checksum engines run side by side on every packet. The first starts from the programmed seed and the second starts from zero. On transmit, a select input picks which engine's result is shown. On receive, the packet passes when the received checksum equals the result of either engine.

A start strobe opens a packet. An end-of-payload flag, given with the last payload byte, closes the payload. A global enable turns the checksum function on or off. Framing, preamble and modulation are handled outside this block.

Top module: `crc16_seeded_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `crc_out` = 0x0000, `crc_out_valid` = 0, `chk_done` = 0 and `chk_pass` = 0.
- R2: Each payload byte is folded in least significant bit first. For each bit b, take fb = crc[0] ^ b, shift crc right by one, and XOR in 0xA001 when fb is 1. No final inversion is applied. For the ASCII bytes "123456789", a seed of 0xFFFF gives 0x4B37 and a seed of 0x0000 gives 0xBB3D.
- R3: In transmit mode, `cfg_tx_zero_seed` = 0 makes `crc_out` the result that started from `cfg_seed`. `cfg_tx_zero_seed` = 1 makes it the result that started from 0x0000.
- R4: In transmit mode with the checksum enabled, `crc_out_valid` is high for exactly one cycle. That cycle is the one after the edge that accepts the byte carrying `in_last`. During it, `crc_out` holds the checksum that includes that byte.
- R5: In receive mode with the checksum enabled, the two accepted bytes after the last payload byte are the received checksum, high byte first. `chk_done` is high for exactly one cycle, the cycle after the edge that accepts the low byte. In that cycle `chk_pass` is 1 if the received value equals the configured-seed result or the zero-seed result.
- R6: A received checksum that matches neither result gives `chk_pass` = 0 with the `chk_done` pulse. This includes every single-bit corruption of a correct checksum.
- R7: `start` reloads both engines and opens a new payload. A byte presented with `in_valid` in the same cycle as `start` is dropped.
- R8: With `cfg_crc_en` = 0, no `crc_out_valid` or `chk_done` pulse occurs. Bytes after the last payload byte are not taken as a checksum.
- R9: Bytes with `in_valid` high outside an open payload (after reset, or after a packet has closed) leave `crc_out` unchanged and raise no pulse.
- R10: Cycles with `in_valid` low between payload bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a packet and reloads both engines |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | 8 | Payload byte or received checksum byte |
| in_last | input | 1 | Marks the last payload byte (sampled with `in_valid`) |
| cfg_seed | input | 16 | Programmable seed |
| cfg_tx_zero_seed | input | 1 | Transmit: 1 selects the zero-seed result |
| cfg_rx_mode | input | 1 | 1 = receive, 0 = transmit |
| cfg_crc_en | input | 1 | Enables checksum output and checking |
| crc_out | output | 16 | Running checksum from the selected engine |
| crc_out_valid | output | 1 | One-cycle pulse: final transmit checksum on `crc_out` |
| chk_done | output | 1 | One-cycle pulse: receive comparison finished |
| chk_pass | output | 1 | Comparison result, valid with `chk_done` |

## Verification
The transmit result is due in the cycle after the edge that accepts the last payload byte. The receive verdict is due in the cycle after the edge that accepts the low checksum byte. Both pulses must be gone one cycle later. The bench drives every input on the falling edge and reads outputs at the next falling edge, which is exactly where each result is due. It then steps one more falling edge to confirm the pulse has dropped. For the ignored-input cases (idle bytes, disabled checksum, a byte alongside `start`), the bench reads `crc_out` or the pulse outputs before any further stimulus is applied.

// File: rtl/crc16_pkg.sv
// Package: shared constants, the packet phase type and the byte-step
// function of the reflected CRC16 (x^16 + x^15 + x^2 + 1).
// Assumes bytes are folded least significant bit first.
package crc16_pkg;

    localparam int CRC_W     = 16;
    localparam int BYTE_W    = 8;
    localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PAYLOAD = 2'd1,
        PH_CRC_HI  = 2'd2,
        PH_CRC_LO  = 2'd3
    } phase_t;

    // Fold one byte into the CRC register, LSB first.
    function automatic logic [CRC_W-1:0] crc_fold_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc16_engine.sv
// Module: one CRC accumulator. It loads SEED on load_i and folds data_i
// on upd_i. Load wins over update. Otherwise the register holds.
// Assumes the controller never raises upd_i together with load_i.
module crc16_engine
    import crc16_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [W-1:0]  seed_i,
    input  logic          upd_i,
    input  logic [DW-1:0] data_i,
    output logic [W-1:0]  crc_o
);

    logic [W-1:0] crc_q;

    // Accumulator register: reset, seed load, byte fold or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '0;
        else if (load_i) crc_q <= seed_i;
        else if (upd_i)  crc_q <= crc_fold_byte(crc_q, data_i);
    end

    assign crc_o = crc_q;

    // R7
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (crc_o == $past(seed_i)));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !upd_i) |=> $stable(crc_o));

endmodule

// File: rtl/crc16_seq_ctrl.sv
// Module: packet phase controller. It tracks payload and checksum-byte
// phases, gates engine updates, raises capture strobes for the two
// received checksum bytes, and registers the transmit result pulse.
// Assumes in_last is meaningful only together with in_valid.
module crc16_seq_ctrl
    import crc16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic in_last,
    input  logic cfg_rx_mode,
    input  logic cfg_crc_en,
    output logic eng_load,
    output logic eng_upd,
    output logic hi_cap,
    output logic lo_cap,
    output logic tx_done
);

    phase_t phase_q, phase_d;
    logic   pay_end;
    logic   tx_done_q;

    // Strobes: start has priority over any data beat.
    always_comb begin
        eng_load = start;
        eng_upd  = !start && in_valid && (phase_q == PH_PAYLOAD);
        hi_cap   = !start && in_valid && (phase_q == PH_CRC_HI);
        lo_cap   = !start && in_valid && (phase_q == PH_CRC_LO);
        pay_end  = eng_upd && in_last;
    end

    // Next phase selection.
    always_comb begin
        phase_d = phase_q;
        if (start) begin
            phase_d = PH_PAYLOAD;
        end else if (pay_end) begin
            phase_d = (cfg_crc_en && cfg_rx_mode) ? PH_CRC_HI : PH_IDLE;
        end else if (hi_cap) begin
            phase_d = PH_CRC_LO;
        end else if (lo_cap) begin
            phase_d = PH_IDLE;
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Transmit result pulse, one cycle after the last payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_done_q <= 1'b0;
        else        tx_done_q <= pay_end && cfg_crc_en && !cfg_rx_mode;
    end

    assign tx_done = tx_done_q;

    // R4
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R8
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_crc_en |=> !tx_done);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_done && phase_q == PH_IDLE));

endmodule

// File: rtl/crc16_rx_check.sv
// Module: receive comparator. It captures the high checksum byte, then
// on the low byte compares the received value with both engine results.
// It pulses done for one cycle and holds pass until the next verdict or start.
// Assumes the engines are frozen while the checksum bytes arrive.
module crc16_rx_check
    import crc16_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hi_cap,
    input  logic          lo_cap,
    input  logic [DW-1:0] data_i,
    input  logic [W-1:0]  crc_seeded,
    input  logic [W-1:0]  crc_zero,
    output logic          done,
    output logic          pass
);

    localparam int HI_W = W - DW;

    logic [HI_W-1:0] hi_q;
    logic [W-1:0]    rcv;
    logic            match;

    // Received value and two-way comparison.
    always_comb begin
        rcv   = {hi_q, data_i};
        match = (rcv == crc_seeded) || (rcv == crc_zero);
    end

    // High-byte capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (hi_cap) hi_q <= data_i[HI_W-1:0];
    end

    // Verdict registers: one-cycle done, sticky pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else begin
            done <= lo_cap;
            if (clear)       pass <= 1'b0;
            else if (lo_cap) pass <= match;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    pass_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_cap && !clear) |=> (pass == ((crc_seeded == $past(rcv)) || (crc_zero == $past(rcv)))));

endmodule

// File: rtl/crc16_seeded_unit.sv
// Module: top of the seeded CRC16 generator/checker. It runs two engines
// (programmed seed, zero seed) side by side. Transmit shows the selected
// one; receive accepts a match with either.
// Assumes configuration inputs are stable during a packet.
module crc16_seeded_unit
    import crc16_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic [W-1:0]  cfg_seed,
    input  logic          cfg_tx_zero_seed,
    input  logic          cfg_rx_mode,
    input  logic          cfg_crc_en,
    output logic [W-1:0]  crc_out,
    output logic          crc_out_valid,
    output logic          chk_done,
    output logic          chk_pass
);

    localparam int N_ENG = 2;

    logic         eng_load, eng_upd, hi_cap, lo_cap, tx_done;
    logic [W-1:0] eng_crc [N_ENG];

    crc16_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .cfg_rx_mode (cfg_rx_mode),
        .cfg_crc_en  (cfg_crc_en),
        .eng_load    (eng_load),
        .eng_upd     (eng_upd),
        .hi_cap      (hi_cap),
        .lo_cap      (lo_cap),
        .tx_done     (tx_done)
    );

    // Engine 0 starts from the programmed seed, engine 1 from zero.
    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        crc16_engine #(.W(W), .DW(DW)) u_eng (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (eng_load),
            .seed_i ((g == 0) ? cfg_seed : {W{1'b0}}),
            .upd_i  (eng_upd),
            .data_i (in_data),
            .crc_o  (eng_crc[g])
        );
    end

    crc16_rx_check #(.W(W), .DW(DW)) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (eng_load),
        .hi_cap     (hi_cap),
        .lo_cap     (lo_cap),
        .data_i     (in_data),
        .crc_seeded (eng_crc[0]),
        .crc_zero   (eng_crc[1]),
        .done       (chk_done),
        .pass       (chk_pass)
    );

    // Transmit result selection.
    assign crc_out       = cfg_tx_zero_seed ? eng_crc[1] : eng_crc[0];
    assign crc_out_valid = tx_done;

    // R8
    en_rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_crc_en |=> !chk_done);

    // R4
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_out_valid && chk_done));

endmodule

// File: tb/sim_crc16_seeded_unit.sv
module sim_crc16_seeded_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic [15:0] cfg_seed = 16'h0000;
    logic        cfg_tx_zero_seed = 1'b0;
    logic        cfg_rx_mode = 1'b0;
    logic        cfg_crc_en = 1'b1;
    logic [15:0] crc_out;
    logic        crc_out_valid, chk_done, chk_pass;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] pl [16];

    always #5 clk = ~clk;

    crc16_seeded_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .cfg_seed(cfg_seed),
        .cfg_tx_zero_seed(cfg_tx_zero_seed), .cfg_rx_mode(cfg_rx_mode),
        .cfg_crc_en(cfg_crc_en), .crc_out(crc_out), .crc_out_valid(crc_out_valid),
        .chk_done(chk_done), .chk_pass(chk_pass)
    );

    // Reference checksum from the R2 rule.
    function automatic logic [15:0] ref_crc(input logic [15:0] init, input int n);
        logic [15:0] c = init;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, pl[i]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_digits();
        for (int i = 0; i < 9; i++) pl[i] = 8'h31 + 8'(i);
    endtask

    // All drives happen at a falling edge; returns at the next one.
    task automatic put(input logic [7:0] d, input logic last);
        in_valid = 1'b1; in_data = d; in_last = last;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_payload(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            put(pl[i], i == n - 1);
            if (gaps && i != n - 1) begin
                @(negedge clk);
                @(negedge clk);
            end
        end
    endtask

    task automatic tx_case(input string req, input logic [15:0] seed, input logic zsel,
                           input int n, input bit gaps, input logic [15:0] exp);
        cfg_rx_mode = 1'b0; cfg_seed = seed; cfg_tx_zero_seed = zsel;
        do_start();
        send_payload(n, gaps);
        check(req, {15'd0, crc_out_valid}, 16'd1);
        check(req, crc_out, exp);
        @(negedge clk);
        check(req, {15'd0, crc_out_valid}, 16'd0);
    endtask

    task automatic rx_case(input string req, input logic [15:0] seed, input int n,
                           input logic [15:0] rcv, input logic exp_pass);
        cfg_rx_mode = 1'b1; cfg_seed = seed;
        do_start();
        send_payload(n, 1'b0);
        put(rcv[15:8], 1'b0);
        check(req, {15'd0, chk_done}, 16'd0);
        put(rcv[7:0], 1'b0);
        check(req, {15'd0, chk_done}, 16'd1);
        check(req, {15'd0, chk_pass}, {15'd0, exp_pass});
        @(negedge clk);
        check(req, {15'd0, chk_done}, 16'd0);
    endtask

    task automatic t_reset();
        // R1
        check("R1", crc_out, 16'h0000);
        check("R1", {15'd0, crc_out_valid}, 16'd0);
        check("R1", {15'd0, chk_done}, 16'd0);
        check("R1", {15'd0, chk_pass}, 16'd0);
    endtask

    task automatic t_tx_seeds();
        load_digits();
        // R2 R3 R4: known values and model agree
        tx_case("R2", 16'hFFFF, 1'b0, 9, 1'b0, 16'h4B37);
        tx_case("R3", 16'hFFFF, 1'b1, 9, 1'b0, 16'hBB3D);
        for (int i = 0; i < 12; i++) pl[i] = 8'(i * 37 + 5);
        tx_case("R4", 16'h1D0F, 1'b0, 12, 1'b0, ref_crc(16'h1D0F, 12));
        tx_case("R3", 16'h1D0F, 1'b1, 1, 1'b0, ref_crc(16'h0000, 1));
    endtask

    task automatic t_gaps_idle();
        logic [15:0] held;
        load_digits();
        // R10
        tx_case("R10", 16'hFFFF, 1'b0, 9, 1'b1, 16'h4B37);
        // R9: bytes after the packet closed
        held = crc_out;
        put(8'h5A, 1'b0);
        put(8'hC3, 1'b1);
        check("R9", crc_out, held);
        check("R9", {15'd0, crc_out_valid}, 16'd0);
    endtask

    task automatic t_start_prio();
        load_digits();
        cfg_rx_mode = 1'b0; cfg_seed = 16'hFFFF; cfg_tx_zero_seed = 1'b0;
        // R7: byte beside start is dropped
        start = 1'b1; in_valid = 1'b1; in_data = 8'hAA;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        check("R7", crc_out, 16'hFFFF);
        send_payload(9, 1'b0);
        check("R7", crc_out, 16'h4B37);
        check("R7", {15'd0, crc_out_valid}, 16'd1);
        @(negedge clk);
    endtask

    task automatic t_rx();
        logic [15:0] good;
        for (int i = 0; i < 7; i++) pl[i] = 8'(8'hF0 ^ (i * 11));
        good = ref_crc(16'h8408, 7);
        // R5
        rx_case("R5", 16'h8408, 7, good, 1'b1);
        rx_case("R5", 16'h8408, 7, ref_crc(16'h0000, 7), 1'b1);
        // R6
        rx_case("R6", 16'h8408, 7, good ^ 16'h0101, 1'b0);
        for (int b = 0; b < 16; b++)
            rx_case("R6", 16'h8408, 7, good ^ (16'h0001 << b), 1'b0);
    endtask

    task automatic t_disable();
        load_digits();
        cfg_crc_en = 1'b0;
        // R8 transmit
        cfg_rx_mode = 1'b0; cfg_seed = 16'hFFFF;
        do_start();
        send_payload(9, 1'b0);
        check("R8", {15'd0, crc_out_valid}, 16'd0);
        // R8 receive: trailing bytes are not a checksum
        cfg_rx_mode = 1'b1;
        do_start();
        send_payload(9, 1'b0);
        put(8'h4B, 1'b0);
        check("R8", {15'd0, chk_done}, 16'd0);
        put(8'h37, 1'b0);
        check("R8", {15'd0, chk_done}, 16'd0);
        @(negedge clk);
        check("R8", {15'd0, chk_done}, 16'd0);
        cfg_crc_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_tx_seeds();
        t_gaps_idle();
        t_start_prio();
        t_rx();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule